// File: doc/BRIEF.md
# Lane Test Pattern Source with Alignment Preamble

This block feeds one lane of a serial-link loopback test with 20-bit parallel words for a serializer. It waits idle until a start request arrives. It then sends an alignment preamble, in which each word holds the 10-bit character 10'h1A7 in both of its halves. It keeps sending that preamble until the lane reports that it is synchronized. From the next word on, it sends a pseudo-random bit sequence from a PRBS-7 generator that advances 20 bits per clock.

Each lane gets its own instance, so every lane keeps its own synchronization state and its own generator state. If a lane loses synchronization, its instance goes back to the preamble and reloads the generator seed. When the lane locks again, the sequence starts over from the seed. The word, a 2-bit phase code and a PRBS-valid flag all come straight from registers.

Top module: `tx_prbs_preamble_src`

## Requirements
- R1: While rst is high at a rising edge, the next outputs are tx_word = 0, tx_phase = 2'b00 (idle) and prbs_active = 0. The phase code never takes the value 2'b11.
- R2: In the idle phase with start_req low, the block stays idle and tx_word stays 0. lane_synced has no effect in this phase.
- R3: When start_req is high in the idle phase, the next word is the alignment word 20'h69DA7 (10'h1A7 in bits 19:10 and again in bits 9:0), and tx_phase = 2'b01.
- R4: In the alignment phase with lane_synced low, every following word is the alignment word and prbs_active stays 0.
- R5: When lane_synced is high in the alignment phase, the next word is the first PRBS word and tx_phase = 2'b10. prbs_active rises on that same word.
- R6: Each PRBS bit is b = s[6] ^ s[5] (polynomial x^7 + x^6 + 1), and the state then becomes {s[5:0], b}. Twenty steps happen per word, and the first bit produced goes to bit 19. The state starts from the seed 7'h7F, and an all-zero seed is rejected at elaboration.
- R7: While lane_synced stays high, consecutive PRBS words continue the sequence with no gap or repeat. No PRBS word is all zeros.
- R8: When lane_synced is low in the PRBS phase, the next word is the alignment word and prbs_active falls. The generator is reseeded, so the next PRBS run starts again with the seed's first word.
- R9: start_req has no effect outside the idle phase.
- R10: If start_req and lane_synced are high together in the idle phase, at least one alignment word is sent before any PRBS word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Begin the alignment preamble (used only when idle) |
| lane_synced | input | 1 | The lane's receiver reports that it is aligned |
| tx_word | output | 20 | Parallel word to the serializer |
| tx_phase | output | 2 | 00 idle, 01 alignment, 10 PRBS |
| prbs_active | output | 1 | High on every word that carries PRBS data |

## Verification
Two decisions can fall in the same cycle. One is the start decision taken when idle and the other is the lock decision taken during alignment. The bench provokes this by raising start_req and lane_synced together while idle, and the scoreboard then expects exactly one alignment word before the first seed word. The bench also keeps start_req high while lane_synced drops during PRBS, and it expects a return to alignment with a reseeded generator rather than any effect from the start request.

// File: rtl/tx_prbs_pkg.sv
package tx_prbs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_ALIGN = 2'b01,
    PH_PRBS  = 2'b10
  } phase_e;

  localparam int          DEF_WORD_W   = 20;
  localparam int          DEF_CHAR_W   = 10;
  localparam logic [9:0]  DEF_ALIGN    = 10'h1A7;
  localparam int          DEF_ORDER    = 7;
  localparam int          DEF_TAP_LO   = 6;
  localparam logic [6:0]  DEF_SEED     = 7'h7F;

endpackage

// File: rtl/tx_prbs_stepper.sv
module tx_prbs_stepper #(
  parameter int ORDER  = 7,
  parameter int TAP_LO = 6,
  parameter int WORD_W = 20
) (
  input  logic [ORDER-1:0]  state_i,
  output logic [WORD_W-1:0] word_o,
  output logic [ORDER-1:0]  next_o
);
  localparam int HI_IDX = ORDER - 1;
  localparam int LO_IDX = TAP_LO - 1;

  // Unrolled bit-serial recurrence: oldest bit lands at the MSB.
  always_comb begin
    logic [ORDER-1:0] s;
    logic             fb;
    s      = state_i;
    word_o = '0;
    for (int k = 0; k < WORD_W; k++) begin
      fb                   = s[HI_IDX] ^ s[LO_IDX];
      word_o[WORD_W-1-k]   = fb;
      s                    = {s[ORDER-2:0], fb};
    end
    next_o = s;
  end
endmodule

// File: rtl/tx_prbs_gen.sv
module tx_prbs_gen #(
  parameter int              ORDER  = 7,
  parameter int              TAP_LO = 6,
  parameter int              WORD_W = 20,
  parameter logic [ORDER-1:0] SEED  = 7'h7F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [WORD_W-1:0] word_o
);
  logic [ORDER-1:0] lfsr_q;
  logic [ORDER-1:0] lfsr_next;

  tx_prbs_stepper #(
    .ORDER (ORDER),
    .TAP_LO(TAP_LO),
    .WORD_W(WORD_W)
  ) u_step (
    .state_i(lfsr_q),
    .word_o (word_o),
    .next_o (lfsr_next)
  );

  // Held at the seed whenever no PRBS word is being emitted.
  always_ff @(posedge clk) begin
    if (rst || !advance) lfsr_q <= SEED;
    else                 lfsr_q <= lfsr_next;
  end
endmodule

// File: rtl/tx_phase_ctrl.sv
module tx_phase_ctrl
  import tx_prbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_req,
  input  logic   lane_synced,
  output phase_e phase_d
);
  phase_e phase_q;

  always_comb begin
    phase_d = phase_q;
    if (rst) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:  if (start_req)    phase_d = PH_ALIGN;
        PH_ALIGN: if (lane_synced)  phase_d = PH_PRBS;
        PH_PRBS:  if (!lane_synced) phase_d = PH_ALIGN;
        default:                    phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phase_q <= phase_d;
  end
endmodule

// File: rtl/tx_out_stage.sv
module tx_out_stage
  import tx_prbs_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase_d,
  input  logic [WORD_W-1:0] prbs_word,
  input  logic [WORD_W-1:0] align_word,
  output logic [WORD_W-1:0] tx_word,
  output logic [1:0]        tx_phase,
  output logic              prbs_active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word     <= '0;
      tx_phase    <= PH_IDLE;
      prbs_active <= 1'b0;
    end else begin
      tx_phase    <= phase_d;
      prbs_active <= (phase_d == PH_PRBS);
      unique case (phase_d)
        PH_PRBS:  tx_word <= prbs_word;
        PH_ALIGN: tx_word <= align_word;
        default:  tx_word <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tx_prbs_preamble_src.sv
module tx_prbs_preamble_src
  import tx_prbs_pkg::*;
#(
  parameter int                WORD_W     = DEF_WORD_W,
  parameter int                CHAR_W     = DEF_CHAR_W,
  parameter logic [CHAR_W-1:0] ALIGN_CHAR = DEF_ALIGN,
  parameter int                ORDER      = DEF_ORDER,
  parameter int                TAP_LO     = DEF_TAP_LO,
  parameter logic [ORDER-1:0]  SEED       = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              lane_synced,
  output logic [WORD_W-1:0] tx_word,
  output logic [1:0]        tx_phase,
  output logic              prbs_active
);
  localparam int HALVES = WORD_W / CHAR_W;

  if (SEED == '0) begin : g_bad_seed
    $error("PRBS seed must be nonzero");
  end

  phase_e            phase_d;
  logic [WORD_W-1:0] prbs_word;
  logic [WORD_W-1:0] align_word;

  for (genvar h = 0; h < HALVES; h++) begin : g_align
    assign align_word[h*CHAR_W +: CHAR_W] = ALIGN_CHAR;
  end
  if (HALVES * CHAR_W < WORD_W) begin : g_align_pad
    assign align_word[WORD_W-1:HALVES*CHAR_W] = '0;
  end

  tx_phase_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .lane_synced(lane_synced),
    .phase_d    (phase_d)
  );

  tx_prbs_gen #(
    .ORDER (ORDER),
    .TAP_LO(TAP_LO),
    .WORD_W(WORD_W),
    .SEED  (SEED)
  ) u_gen (
    .clk    (clk),
    .rst    (rst),
    .advance(phase_d == PH_PRBS),
    .word_o (prbs_word)
  );

  tx_out_stage #(
    .WORD_W(WORD_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .phase_d    (phase_d),
    .prbs_word  (prbs_word),
    .align_word (align_word),
    .tx_word    (tx_word),
    .tx_phase   (tx_phase),
    .prbs_active(prbs_active)
  );
endmodule

// File: rtl/tx_prbs_preamble_src_chk.sv
module tx_prbs_preamble_src_chk #(
  parameter int                WORD_W     = 20,
  parameter int                CHAR_W     = 10,
  parameter logic [CHAR_W-1:0] ALIGN_CHAR = 10'h1A7
) (
  input logic              clk,
  input logic              rst,
  input logic              start_req,
  input logic              lane_synced,
  input logic [WORD_W-1:0] tx_word,
  input logic [1:0]        tx_phase,
  input logic              prbs_active
);
  localparam logic [WORD_W-1:0] FULL_ALIGN = {(WORD_W/CHAR_W){ALIGN_CHAR}};

  assert_legal_phase_R1: assert property (@(posedge clk) disable iff (rst)
    tx_phase != 2'b11);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_phase == 2'b00 && !start_req) |=> (tx_phase == 2'b00 && tx_word == '0));

  assert_start_align_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_phase == 2'b00 && start_req) |=> (tx_phase == 2'b01 && tx_word == FULL_ALIGN));

  assert_align_word_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_phase == 2'b01) |-> (tx_word == FULL_ALIGN && !prbs_active));

  assert_first_prbs_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(prbs_active) |-> ($past(tx_phase) == 2'b01 && $past(lane_synced)));

  assert_nonzero_prbs_R7: assert property (@(posedge clk) disable iff (rst)
    prbs_active |-> tx_word != '0);

  assert_sync_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_phase == 2'b10 && !lane_synced) |=> (tx_phase == 2'b01 && !prbs_active));
endmodule

bind tx_prbs_preamble_src tx_prbs_preamble_src_chk #(
  .WORD_W    (WORD_W),
  .CHAR_W    (CHAR_W),
  .ALIGN_CHAR(ALIGN_CHAR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_req  (start_req),
  .lane_synced(lane_synced),
  .tx_word    (tx_word),
  .tx_phase   (tx_phase),
  .prbs_active(prbs_active)
);

// File: tb/tx_prbs_preamble_src_test.sv
module tx_prbs_preamble_src_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_req = 1'b0;
  logic        lane_synced = 1'b0;
  logic [19:0] tx_word;
  logic [1:0]  tx_phase;
  logic        prbs_active;

  localparam logic [19:0] ALIGN_W = 20'h69DA7;
  localparam logic [6:0]  SEED_V  = 7'h7F;

  always #5 clk = ~clk;

  tx_prbs_preamble_src uut (
    .clk(clk), .rst(rst), .start_req(start_req), .lane_synced(lane_synced),
    .tx_word(tx_word), .tx_phase(tx_phase), .prbs_active(prbs_active)
  );

  logic [19:0] q_word[$];
  logic [1:0]  q_ph[$];
  logic        q_act[$];
  string       q_tag[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  int          m_ph = 0;
  logic [6:0]  m_lfsr = SEED_V;

  // PRBS-7, x^7+x^6+1, first bit at bit 19
  function automatic logic [19:0] gen_word(input logic [6:0] s_in, output logic [6:0] s_out);
    logic [19:0] w;
    logic [6:0]  s;
    s = s_in;
    w = '0;
    for (int i = 19; i >= 0; i--) begin
      logic b;
      b = s[6] ^ s[5];
      w[i] = b;
      s = {s[5:0], b};
    end
    s_out = s;
    return w;
  endfunction

  task automatic step(input logic r, input logic st, input logic sy, input string tag);
    logic [19:0] w;
    logic [6:0]  nl;
    @(negedge clk);
    rst = r; start_req = st; lane_synced = sy;
    w = '0;
    if (r) begin
      m_ph = 0; m_lfsr = SEED_V; w = '0;
    end else begin
      case (m_ph)
        0: if (st) begin m_ph = 1; w = ALIGN_W; end
        1: if (sy) begin m_ph = 2; w = gen_word(m_lfsr, nl); m_lfsr = nl; end
           else w = ALIGN_W;
        default: if (!sy) begin m_ph = 1; w = ALIGN_W; m_lfsr = SEED_V; end
                 else begin w = gen_word(m_lfsr, nl); m_lfsr = nl; end
      endcase
    end
    q_word.push_back(w);
    q_ph.push_back(2'(m_ph));
    q_act.push_back(m_ph == 2);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares one expected item after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_word.size() > 0) begin
        logic [19:0] ew;
        logic [1:0]  ep;
        logic        ea;
        string       t;
        ew = q_word.pop_front(); ep = q_ph.pop_front();
        ea = q_act.pop_front();  t  = q_tag.pop_front();
        checks++;
        if (tx_word !== ew || tx_phase !== ep || prbs_active !== ea) begin
          fails++;
          $display("FAIL %s: word=%h phase=%b act=%b expected word=%h phase=%b act=%b",
                   t, tx_word, tx_phase, prbs_active, ew, ep, ea);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R1");
    // idle, lane_synced toggling must have no effect
    step(0, 0, 1, "R2"); step(0, 0, 0, "R2"); step(0, 0, 1, "R2");
    step(0, 1, 0, "R3");
    // alignment continues; start_req held high is ignored
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R4_R9");
    step(0, 0, 1, "R5");
    for (int i = 0; i < 30; i++) step(0, i[0], 1, "R6_R7_R9");
    // sync drop with start_req high
    step(0, 1, 0, "R8");
    step(0, 0, 0, "R4");
    step(0, 0, 1, "R8_reseed");
    for (int i = 0; i < 8; i++) step(0, 0, 1, "R7");
    // single-cycle glitch of sync
    step(0, 0, 0, "R8");
    step(0, 0, 1, "R8_reseed");
    step(0, 0, 1, "R6");
    // reset in the middle of PRBS
    step(1, 0, 1, "R1");
    // start and sync together while idle
    step(0, 1, 1, "R10");
    step(0, 1, 1, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 1, "R7");
    step(0, 0, 0, "R8");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule